// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block takes one IEEE-754 operand per transaction, either binary32 or binary64, and returns its value as a signed two's-complement integer. The integer is 32 or 64 bits wide. Any fractional part is discarded, so the conversion truncates toward zero. An operand that no integer of the chosen width can represent does not wrap. It gives a fixed saturated code and raises an invalid flag. One case is exempt: a negative operand exactly equal to the most negative integer converts cleanly.

Operands arrive on a 64-bit bus with a valid/ready handshake. One select bit picks the operand format and a second picks the result width. A 32-bit result is sign-extended across the full 64-bit output. The block has one register stage. A result appears one cycle after it is accepted and stays frozen until the consumer takes it.

Top module: `fp2int_cvt`

## Requirements
- R1: Any NaN operand, quiet or signalling, gives the most negative integer of the selected width and sets `out_invalid`.
- R2: An infinity gives the most positive integer when its sign bit is 0 and the most negative integer when its sign bit is 1, and sets `out_invalid`.
- R3: A zero operand of either sign gives 0 with `out_invalid` clear.
- R4: A finite operand with magnitude below one, including every subnormal, gives 0 with `out_invalid` clear.
- R5: A finite operand whose unbiased exponent E satisfies 0 <= E < W-1 (W = selected result width) gives its value truncated toward zero, with `out_invalid` clear.
- R6: A finite operand with E >= W-1 saturates to the most positive integer when positive and the most negative integer when negative, and sets `out_invalid`. The only exception is the case in R7.
- R7: An operand exactly equal to -2^(W-1) gives -2^(W-1) with `out_invalid` clear.
- R8: `in_wide` = 0 selects W = 32, and the result is sign-extended from bit 31 into bits 63:32. `in_wide` = 1 selects W = 64.
- R9: `in_dbl` = 1 decodes the whole bus as binary64 (sign bit 63, 11-bit exponent in bits 62:52, fraction in bits 51:0). `in_dbl` = 0 decodes bits 31:0 as binary32 (sign bit 31, 8-bit exponent in bits 30:23, fraction in bits 22:0) and ignores bits 63:32.
- R10: An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` on the next cycle. While `out_valid` is high and `out_ready` is low, `out_value` and `out_invalid` do not change. `in_ready` is high exactly when the output register is empty or being drained.
- R11: A low `rst_n` on a rising edge clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_dbl | input | 1 | 1: binary64 operand, 0: binary32 operand in the low half |
| in_wide | input | 1 | 1: 64-bit result, 0: 32-bit result sign-extended |
| in_operand | input | 64 | Floating-point operand bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_value | output | 64 | Signed integer result |
| out_invalid | output | 1 | Invalid-conversion flag |

## Verification
On every cycle, the assertions check the output-side rules that do not depend on the operand's value. A stalled result must stay frozen. An accepted operand must produce a result on the next cycle. A 32-bit result must be properly sign-extended. A raised flag must come with one of the saturation codes of the width in use. A zero result must never carry the flag. Whether a given operand lands on the right code depends on its value, so only the bench scenarios show that. Those scenarios cover NaN and infinity decoding in both formats, truncation of both signs, the exponent boundary around W-1, the exact-minimum exception, subnormals, and the ignored upper half of the bus.

// File: rtl/fp2int_pkg.sv
// Shared types for the float-to-integer converter.
// Assumes at most binary64 operands and at most 64-bit results.
package fp2int_pkg;

    // Width of the result bus.
    localparam int OUT_W   = 64;
    // Mantissa width including the hidden one (binary64 precision).
    localparam int MANT_W  = 53;
    // Signed width that holds any unbiased exponent of either format.
    localparam int EXP_W   = 13;

    // Operand class after decoding.
    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_TINY = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } fp_class_e;

    // Format-independent view of an operand: the mantissa is left-aligned,
    // with the hidden one at bit MANT_W-1.
    typedef struct packed {
        logic                     sign;
        fp_class_e                cls;
        logic signed [EXP_W-1:0]  exp;
        logic [MANT_W-1:0]        mant;
    } fp_unpacked_t;

endpackage

// File: rtl/fp2int_field.sv
// Decodes one IEEE-754 format into the common unpacked view.
// Assumes FRAC_BITS < MANT_W and that the exponent fits in EXP_W signed bits.
module fp2int_field
    import fp2int_pkg::*;
#(
    parameter int EXP_BITS  = 11,
    parameter int FRAC_BITS = 52
) (
    input  logic [EXP_BITS+FRAC_BITS:0] bits,
    output fp_unpacked_t                u
);
    localparam int TOP_BIT = EXP_BITS + FRAC_BITS;
    localparam int BIAS    = (1 << (EXP_BITS - 1)) - 1;
    localparam int PAD_W   = MANT_W - 1 - FRAC_BITS;

    logic [EXP_BITS-1:0]  biased;
    logic [FRAC_BITS-1:0] frac;
    logic                 exp_all0;
    logic                 exp_all1;
    logic                 frac_zero;
    logic [EXP_W-1:0]     biased_ext;

    assign biased     = bits[TOP_BIT-1:FRAC_BITS];
    assign frac       = bits[FRAC_BITS-1:0];
    assign exp_all0   = (biased == '0);
    assign exp_all1   = (biased == '1);
    assign frac_zero  = (frac == '0);
    assign biased_ext = {{(EXP_W-EXP_BITS){1'b0}}, biased};

    // Sort the encoding into a class and build the aligned magnitude.
    always_comb begin
        u.sign = bits[TOP_BIT];
        u.exp  = $signed(biased_ext - EXP_W'(BIAS));
        u.mant = {1'b1, frac, {PAD_W{1'b0}}};
        if (exp_all1) begin
            u.cls = frac_zero ? CLS_INF : CLS_NAN;
        end else if (exp_all0) begin
            u.cls = frac_zero ? CLS_ZERO : CLS_TINY;
        end else begin
            u.cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fp2int_unpack.sv
// Decodes the operand bus in both supported formats and selects one.
// Assumes binary32 operands sit in the low 32 bits of the bus.
module fp2int_unpack
    import fp2int_pkg::*;
#(
    parameter int BUS_W = 64
) (
    input  logic [BUS_W-1:0] operand,
    input  logic             dbl,
    output fp_unpacked_t     u
);
    localparam int NFMT = 2;
    localparam int FMT_EXP  [NFMT] = '{8, 11};
    localparam int FMT_FRAC [NFMT] = '{23, 52};

    fp_unpacked_t dec [NFMT];

    // One decoder per supported format, each reading the low bits it needs.
    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
        localparam int FW = FMT_EXP[g] + FMT_FRAC[g] + 1;
        fp2int_field #(
            .EXP_BITS  (FMT_EXP[g]),
            .FRAC_BITS (FMT_FRAC[g])
        ) u_field (
            .bits (operand[FW-1:0]),
            .u    (dec[g])
        );
    end

    // Pick the decode matching the precision select.
    always_comb begin
        u = dbl ? dec[1] : dec[0];
    end

endmodule

// File: rtl/fp2int_align.sv
// Turns an unpacked operand into a truncated signed integer, saturating
// out-of-range and special operands and flagging them as invalid.
// Assumes the exponent of a normal operand never exceeds OUT_W+MANT_W.
module fp2int_align
    import fp2int_pkg::*;
#(
    parameter int OUT_W_P  = OUT_W,
    parameter int NARROW_W = 32
) (
    input  fp_unpacked_t        u,
    input  logic                wide,
    output logic [OUT_W_P-1:0]  value,
    output logic                invalid
);
    localparam int SH_W   = $clog2(OUT_W_P);
    localparam int FRAC_P = MANT_W - 1;
    localparam logic [OUT_W_P-1:0] MIN_WIDE   = {1'b1, {(OUT_W_P-1){1'b0}}};
    localparam logic [OUT_W_P-1:0] MIN_NARROW =
        {{(OUT_W_P-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};
    localparam logic [MANT_W-1:0] UNIT_MANT = {1'b1, {(MANT_W-1){1'b0}}};

    logic signed [EXP_W-1:0] limit;
    logic [OUT_W_P-1:0]      sat_min;
    logic [OUT_W_P-1:0]      sat_max;
    logic                    exact_min;
    logic                    too_big;
    logic                    frac_part;
    logic [SH_W-1:0]         sh_right;
    logic [SH_W-1:0]         sh_left;
    logic [OUT_W_P-1:0]      mant_ext;
    logic [OUT_W_P-1:0]      mag;
    logic [OUT_W_P-1:0]      signed_val;
    logic [OUT_W_P-1:0]      fitted;

    // Width-dependent limits and saturation codes.
    always_comb begin
        limit   = wide ? EXP_W'(OUT_W_P - 1) : EXP_W'(NARROW_W - 1);
        sat_min = wide ? MIN_WIDE : MIN_NARROW;
        sat_max = ~sat_min;
    end

    // Range tests on the exponent, with the exact-minimum exception.
    always_comb begin
        exact_min = u.sign && (u.exp == limit) && (u.mant == UNIT_MANT);
        too_big   = (u.exp >= limit) && !exact_min;
        frac_part = (u.exp < 0);
    end

    // Align the mantissa so its binary point sits at bit 0.
    always_comb begin
        mant_ext = {{(OUT_W_P-MANT_W){1'b0}}, u.mant};
        sh_right = SH_W'(FRAC_P) - u.exp[SH_W-1:0];
        sh_left  = u.exp[SH_W-1:0] - SH_W'(FRAC_P);
        if (u.exp > EXP_W'(FRAC_P)) begin
            mag = mant_ext << sh_left;
        end else begin
            mag = mant_ext >> sh_right;
        end
    end

    // Apply the sign, then sign-extend when a narrow result is selected.
    always_comb begin
        signed_val = u.sign ? (~mag + 1'b1) : mag;
        if (wide) begin
            fitted = signed_val;
        end else begin
            fitted = {{(OUT_W_P-NARROW_W){signed_val[NARROW_W-1]}},
                      signed_val[NARROW_W-1:0]};
        end
    end

    // Choose the final code by operand class.
    always_comb begin
        value   = '0;
        invalid = 1'b0;
        unique case (u.cls)
            CLS_NAN: begin
                value   = sat_min;
                invalid = 1'b1;
            end
            CLS_INF: begin
                value   = u.sign ? sat_min : sat_max;
                invalid = 1'b1;
            end
            CLS_NORM: begin
                if (frac_part) begin
                    value = '0;
                end else if (too_big) begin
                    value   = u.sign ? sat_min : sat_max;
                    invalid = 1'b1;
                end else begin
                    value = fitted;
                end
            end
            default: begin
                value   = '0;
                invalid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fp2int_outreg.sv
// Single output register with a valid/ready handshake on both sides.
// Assumes the producer's data is combinational from the accepted operand.
module fp2int_outreg #(
    parameter int DATA_W = 65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    // Accept when empty or when the held item leaves this cycle.
    assign up_ready = !dn_valid || dn_ready;

    // Occupancy of the register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
        end
    end

    // Payload capture, frozen while a result waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_data <= '0;
        end else if (up_valid && up_ready) begin
            dn_data <= up_data;
        end
    end

endmodule

// File: rtl/fp2int_cvt.sv
// Top level: floating-point operand in, truncated signed integer out,
// with one registered stage and valid/ready on both sides.
// Assumes a 64-bit operand bus and a 64-bit result bus.
module fp2int_cvt
    import fp2int_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dbl,
    input  logic             in_wide,
    input  logic [63:0]      in_operand,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_value,
    output logic             out_invalid
);
    localparam int PAY_W = OUT_W + 1;

    fp_unpacked_t       unp;
    logic [OUT_W-1:0]   conv_value;
    logic               conv_invalid;
    logic [PAY_W-1:0]   held;

    fp2int_unpack #(.BUS_W(64)) u_unpack (
        .operand (in_operand),
        .dbl     (in_dbl),
        .u       (unp)
    );

    fp2int_align #(.OUT_W_P(OUT_W), .NARROW_W(32)) u_align (
        .u       (unp),
        .wide    (in_wide),
        .value   (conv_value),
        .invalid (conv_invalid)
    );

    fp2int_outreg #(.DATA_W(PAY_W)) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  ({conv_invalid, conv_value}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (held)
    );

    assign out_value   = held[OUT_W-1:0];
    assign out_invalid = held[OUT_W];

endmodule

// File: rtl/fp2int_cvt_chk.sv
// Property checker for fp2int_cvt, bound to every instance of the top.
// Tracks the width select of the accepted operand to judge output codes.
module fp2int_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_wide,
    input logic        out_valid,
    input logic        out_ready,
    input logic [63:0] out_value,
    input logic        out_invalid
);
    logic wide_cap;

    // Width select of the operand whose result is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_cap <= 1'b1;
        end else if (in_valid && in_ready) begin
            wide_cap <= in_wide;
        end
    end

    p_reset_r11: assert property (@(posedge clk) !rst_n |=> !out_valid);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_value) && $stable(out_invalid)));

    p_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_cap) |-> (out_value[63:32] == {32{out_value[31]}}));

    p_zero_noflag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_value == 64'd0) |-> !out_invalid);

    p_flag_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid) |->
            (wide_cap ? (out_value == 64'h8000_0000_0000_0000 ||
                         out_value == 64'h7FFF_FFFF_FFFF_FFFF)
                      : (out_value == 64'hFFFF_FFFF_8000_0000 ||
                         out_value == 64'h0000_0000_7FFF_FFFF)));

endmodule

bind fp2int_cvt fp2int_cvt_chk u_chk (.*);

// File: tb/fp2int_cvt_tb.sv
// Scoreboard bench: the driver queues expected results, the monitor
// compares them as the design hands results over.
module fp2int_cvt_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_dbl = 1'b0;
    logic        in_wide = 1'b0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_value;
    logic        out_invalid;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit run_mon = 1'b0;

    logic [63:0] q_val [$];
    logic        q_inv [$];
    string       q_tag [$];

    localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAX64 = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN32 = 64'hFFFF_FFFF_8000_0000;
    localparam logic [63:0] MAX32 = 64'h0000_0000_7FFF_FFFF;

    fp2int_cvt u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_dbl      (in_dbl),
        .in_wide     (in_wide),
        .in_operand  (in_operand),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_value   (out_value),
        .out_invalid (out_invalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Offer one operand and queue its expected result.
    task automatic send(input logic [63:0] op, input bit dbl, input bit wide,
                        input logic [63:0] ev, input bit einv, input string tag);
        bit ok;
        @(negedge clk);
        #1;
        in_valid   = 1'b1;
        in_operand = op;
        in_dbl     = dbl;
        in_wide    = wide;
        q_val.push_back(ev);
        q_inv.push_back(einv);
        q_tag.push_back(tag);
        forever begin
            ok = in_ready;
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
            #1;
        end
        #1;
        in_valid = 1'b0;
    endtask

    // Monitor: set the consumer's ready, then compare any result taken.
    initial begin
        logic [63:0] held_val;
        logic        held_inv;
        bit          held = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (run_mon) begin
                out_ready = ((cyc % 5) != 3) && ((cyc % 7) != 2);
                if (held) begin
                    check(out_valid && out_value == held_val && out_invalid == held_inv,
                          "R10 hold while stalled", out_value, held_val);
                end
                held     = out_valid && !out_ready;
                held_val = out_value;
                held_inv = out_invalid;
                if (out_valid && out_ready) begin
                    if (q_val.size() == 0) begin
                        check(1'b0, "R10 unexpected result", out_value, 64'd0);
                    end else begin
                        logic [63:0] ev;
                        logic        ei;
                        string       tg;
                        ev = q_val.pop_front();
                        ei = q_inv.pop_front();
                        tg = q_tag.pop_front();
                        check(out_value == ev, {tg, " value"}, out_value, ev);
                        check(out_invalid == ei, {tg, " flag"},
                              {63'd0, out_invalid}, {63'd0, ei});
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11 out_valid in reset", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R10 ready after reset", {63'd0, in_ready}, 64'd1);
        check(out_valid == 1'b0, "R11 idle after reset", {63'd0, out_valid}, 64'd0);
        run_mon = 1'b1;

        // R1: NaN
        send(64'h7FF8_0000_0000_0000, 1, 1, MIN64, 1, "R1 qnan64 w64");
        send(64'h7FF0_0000_0000_0001, 1, 0, MIN32, 1, "R1 snan64 w32");
        send(64'h0000_0000_7FC0_0000, 0, 1, MIN64, 1, "R1 qnan32 w64");
        send(64'h0000_0000_FF80_0001, 0, 0, MIN32, 1, "R1 snan32 w32");
        // R2: infinity
        send(64'h7FF0_0000_0000_0000, 1, 1, MAX64, 1, "R2 +inf w64");
        send(64'hFFF0_0000_0000_0000, 1, 1, MIN64, 1, "R2 -inf w64");
        send(64'h0000_0000_7F80_0000, 0, 0, MAX32, 1, "R2 +inf32 w32");
        send(64'h0000_0000_FF80_0000, 0, 0, MIN32, 1, "R2 -inf32 w32");
        // R3: zero
        send(64'h0000_0000_0000_0000, 1, 1, 64'd0, 0, "R3 +0");
        send(64'h8000_0000_0000_0000, 1, 0, 64'd0, 0, "R3 -0");
        send(64'h0000_0000_8000_0000, 0, 1, 64'd0, 0, "R3 -0 f32");
        // R4: under one, subnormals
        send(64'h3FE8_0000_0000_0000, 1, 1, 64'd0, 0, "R4 0.75");
        send($realtobits(-0.999), 1, 0, 64'd0, 0, "R4 -0.999");
        send(64'h0000_0000_0000_0001, 1, 1, 64'd0, 0, "R4 subnormal64");
        send(64'h0000_0000_8000_0001, 0, 0, 64'd0, 0, "R4 subnormal32");
        // R5: truncation toward zero
        send($realtobits(2.9), 1, 1, 64'd2, 0, "R5 2.9");
        send($realtobits(-2.9), 1, 1, -64'sd2, 0, "R5 -2.9");
        send(64'h0000_0000_4070_0000, 0, 0, 64'd3, 0, "R5 f32 3.75");
        send(64'h0000_0000_C020_0000, 0, 0, -64'sd2, 0, "R5 f32 -2.5");
        send(64'h43D0_0000_0000_0001, 1, 1, 64'h4000_0000_0000_0400, 0, "R5 large exact");
        send(64'h41DF_FFFF_FFC0_0000, 1, 0, MAX32, 0, "R5 2^31-1 w32");
        for (int k = 0; k < 40; k++) begin
            real r;
            int  iv;
            r  = (real'(k * k) * 1234.5678 + 0.3) * ((k % 2 == 1) ? -1.0 : 1.0);
            iv = $rtoi(r);
            send($realtobits(r), 1, (k % 3 != 0), 64'(longint'(iv)), 0, "R5 sweep");
        end
        // R6: saturation
        send(64'h43E0_0000_0000_0000, 1, 1, MAX64, 1, "R6 2^63 w64");
        send(64'hC3E0_0000_0000_0001, 1, 1, MIN64, 1, "R6 below -2^63");
        send(64'h41E0_0000_0000_0000, 1, 0, MAX32, 1, "R6 2^31 w32");
        send(64'hC1E0_0000_0020_0000, 1, 0, MIN32, 1, "R6 -2^31-1 w32");
        send(64'hC1E0_0000_0010_0000, 1, 0, MIN32, 1, "R6 -2^31-0.5 w32");
        send(64'h0000_0000_4F00_0000, 0, 0, MAX32, 1, "R6 f32 2^31 w32");
        send(64'h0000_0000_7F7F_FFFF, 0, 1, MAX64, 1, "R6 f32 max w64");
        // R7: exact minimum
        send(64'hC3E0_0000_0000_0000, 1, 1, MIN64, 0, "R7 -2^63");
        send(64'hC1E0_0000_0000_0000, 1, 0, MIN32, 0, "R7 -2^31 w32");
        send(64'h0000_0000_CF00_0000, 0, 0, MIN32, 0, "R7 f32 -2^31");
        // R8: width select
        send(64'hBFF0_0000_0000_0000, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 -1 w32");
        send(64'h0000_0000_4F00_0000, 0, 1, 64'h0000_0000_8000_0000, 0, "R8 2^31 w64");
        send(64'h41E0_0000_0000_0000, 1, 1, 64'h0000_0000_8000_0000, 0, "R8 2^31 w64 dbl");
        // R9: upper half ignored for binary32
        send(64'hDEAD_BEEF_4070_0000, 0, 1, 64'd3, 0, "R9 upper ignored");
        send(64'hFFF8_0000_0000_0000, 0, 1, 64'd0, 0, "R9 f32 zero under nan bits");

        for (int w = 0; w < 2000 && q_val.size() != 0; w++) begin
            @(negedge clk);
        end
        check(q_val.size() == 0, "R10 all results delivered",
              64'(q_val.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule